// File: doc/BRIEF.md
# Shared-Bus Request Issue Gate

This block decides, one bus clock at a time, whether a symmetric agent on a shared front-side bus may launch the next transaction from its local request queue. Requests enter through a valid/ready port and wait in a small in-order queue. The queue head leaves as a one-cycle issue strobe, together with its payload and lock flags. A request leaves only when three conditions hold: the agent is requesting the bus, the arbiter grants it ownership, and no stall, priority override or bus-initialization recovery is in force.

The stall, priority, initialization and bus-request pins are active low. The block samples them on the rising clock edge. Where the signals compete, a bus-initialization recovery wins first, then a stall, then a priority override, and normal issue comes last.

During a priority override the gate still lets through a queue head that continues a locked sequence already under way. An observed bus initialization clears only the lock tracker and the arbitration state. Queued entries survive it, so the agent asks for the bus again and carries on where it stopped. Two configuration bits are taken while reset is held: one enables observing the initialization input, the other enables driving the initialization output.

Top module: `bus_issue_gate`

## Requirements
- R1: The request port accepts an entry when `enq_valid` and `enq_ready` are both high at a rising edge. `enq_ready` is low while `DEPTH` entries are held, and an offer made then is dropped. Entries are issued in the order they were accepted.
- R2: An issue (`iss_valid` high for one cycle, with the entry on `iss_data`/`iss_lock`/`iss_last`) appears in the cycle after a rising edge at which `grant` was high and `breq_n` was low. At most one entry is issued per cycle, and none is issued while `grant` is low.
- R3: No entry is issued after an edge at which `stall_n` was low.
- R4: No entry is issued after an edge at which `prio_n` was low, with one exception: a lock sequence is active and the head entry has `lock` set.
- R5: Issuing an entry with `lock`=1 and `last`=0 makes a lock sequence active. Issuing an entry with `lock`=1 and `last`=1 ends it.
- R6: When observation is enabled and `binit_n` is low at an edge, that edge issues nothing and clears the lock sequence. `breq_n` is high in the following cycle and queued entries stay. One cycle later the agent requests again, and the entries are then issued in order.
- R7: With observation disabled, `binit_n` has no effect on issue or on `breq_n`.
- R8: With drive enabled, `binit_out_n` is low in the cycle after an edge where `fault` was high, and high otherwise. With drive disabled it stays high.
- R9: The configuration pins are taken at the last rising edge with `rst_n` low. Later changes to them have no effect until the next reset.
- R10: `breq_n` goes low one edge after the queue holds an entry. It returns high at the first edge that finds the queue empty and no lock sequence active.
- R11: After reset, `iss_valid` is low, `breq_n` and `binit_out_n` are high, and `enq_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_observe | input | 1 | Config: observe initialization input |
| cfg_drive | input | 1 | Config: drive initialization output |
| enq_valid | input | 1 | Request offered |
| enq_ready | output | 1 | Queue has room |
| enq_data | input | DATA_W | Request payload |
| enq_lock | input | 1 | Entry belongs to a locked sequence |
| enq_last | input | 1 | Entry ends its locked sequence |
| grant | input | 1 | Bus ownership from arbiter |
| breq_n | output | 1 | Bus request, active low |
| stall_n | input | 1 | Block-next-request stall, active low |
| prio_n | input | 1 | Priority-agent request, active low |
| binit_n | input | 1 | Bus initialization input, active low |
| fault | input | 1 | Local unrecoverable bus condition |
| binit_out_n | output | 1 | Bus initialization drive, active low |
| iss_valid | output | 1 | Issue strobe |
| iss_data | output | DATA_W | Issued payload |
| iss_lock | output | 1 | Issued entry lock flag |
| iss_last | output | 1 | Issued entry last flag |

## Verification
The hardest situation to reach from the ports is a bus initialization that arrives partway through a locked sequence under a priority override. It must clear the lock, so the continuation that would otherwise pass must now wait. The stimulus loads a locked pair while `grant` is low and issues the first half. It then pulses `binit_n` and holds `prio_n` low through the re-request. No issue may appear until the override lifts, and then the second half must come out next in order. A second reset with observation and drive disabled, followed by pin changes, shows that the captured configuration holds.

// File: rtl/big_pkg.sv
package big_pkg;
  typedef enum logic {ARB_IDLE = 1'b0, ARB_REQ = 1'b1} arb_state_t;

  typedef struct packed {
    logic lock;
    logic last;
  } lock_flags_t;
endpackage

// File: rtl/big_req_fifo.sv
module big_req_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [DATA_W-1:0]   push_data,
  input  big_pkg::lock_flags_t push_flags,
  input  logic                pop,
  output logic                full,
  output logic                has_head,
  output logic [DATA_W-1:0]   head_data,
  output big_pkg::lock_flags_t head_flags,
  output logic [CW-1:0]       fill
);
  logic [DATA_W-1:0]    data_mem [DEPTH];
  big_pkg::lock_flags_t flag_mem [DEPTH];
  logic [AW-1:0]        wr_ptr, rd_ptr;
  logic                 do_push, do_pop;

  assign full     = (fill == CW'(DEPTH));
  assign has_head = (fill != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && has_head;

  assign head_data  = data_mem[rd_ptr];
  assign head_flags = flag_mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) begin
      data_mem[wr_ptr] <= push_data;
      flag_mem[wr_ptr] <= push_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/big_arb_fsm.sv
module big_arb_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic binit_hit,
  input  logic has_head,
  input  logic lock_q,
  output logic arb_req,
  output logic breq_n
);
  import big_pkg::*;
  arb_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (binit_hit) begin
      state_d = ARB_IDLE;
    end else begin
      unique case (state_q)
        ARB_IDLE: if (has_head) state_d = ARB_REQ;
        ARB_REQ:  if (!has_head && !lock_q) state_d = ARB_IDLE;
        default:  state_d = ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign arb_req = (state_q == ARB_REQ);
  assign breq_n  = !arb_req;
endmodule

// File: rtl/big_lock_track.sv
module big_lock_track (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 binit_hit,
  input  logic                 fire,
  input  big_pkg::lock_flags_t head_flags,
  output logic                 lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        lock_q <= 1'b0;
    else if (binit_hit)                lock_q <= 1'b0;
    else if (fire && head_flags.lock)  lock_q <= !head_flags.last;
  end
endmodule

// File: rtl/bus_issue_gate.sv
module bus_issue_gate #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_observe,
  input  logic              cfg_drive,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [DATA_W-1:0] enq_data,
  input  logic              enq_lock,
  input  logic              enq_last,
  input  logic              grant,
  output logic              breq_n,
  input  logic              stall_n,
  input  logic              prio_n,
  input  logic              binit_n,
  input  logic              fault,
  output logic              binit_out_n,
  output logic              iss_valid,
  output logic [DATA_W-1:0] iss_data,
  output logic              iss_lock,
  output logic              iss_last
);
  import big_pkg::*;

  logic              obs_q, drv_q;
  logic              binit_hit, fire, full, has_head, lock_q, arb_req;
  logic [DATA_W-1:0] head_data;
  lock_flags_t       head_flags, push_flags;
  logic [CW-1:0]     fill;
  logic              cont_ok, pass_prio;

  // configuration taken while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obs_q <= cfg_observe;
      drv_q <= cfg_drive;
    end
  end

  assign binit_hit = obs_q && !binit_n;
  assign cont_ok   = lock_q && head_flags.lock;
  assign pass_prio = prio_n || cont_ok;
  // recovery, then stall, then priority, then normal issue
  assign fire = !binit_hit && stall_n && pass_prio && arb_req && grant && has_head;

  assign push_flags = '{lock: enq_lock, last: enq_last};
  assign enq_ready  = !full;

  big_req_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (enq_valid),
    .push_data  (enq_data),
    .push_flags (push_flags),
    .pop        (fire),
    .full       (full),
    .has_head   (has_head),
    .head_data  (head_data),
    .head_flags (head_flags),
    .fill       (fill)
  );

  big_arb_fsm u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .binit_hit (binit_hit),
    .has_head  (has_head),
    .lock_q    (lock_q),
    .arb_req   (arb_req),
    .breq_n    (breq_n)
  );

  big_lock_track u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .binit_hit  (binit_hit),
    .fire       (fire),
    .head_flags (head_flags),
    .lock_q     (lock_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_valid   <= 1'b0;
      iss_data    <= '0;
      iss_lock    <= 1'b0;
      iss_last    <= 1'b0;
      binit_out_n <= 1'b1;
    end else begin
      iss_valid   <= fire;
      binit_out_n <= !(drv_q && fault);
      if (fire) begin
        iss_data <= head_data;
        iss_lock <= head_flags.lock;
        iss_last <= head_flags.last;
      end
    end
  end
endmodule

// File: rtl/bus_issue_gate_chk.sv
module bus_issue_gate_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          obs_q,
  input logic          drv_q,
  input logic          binit_n,
  input logic          stall_n,
  input logic          prio_n,
  input logic          grant,
  input logic          fault,
  input logic          lock_q,
  input logic [CW-1:0] fill,
  input logic          enq_valid,
  input logic          enq_ready,
  input logic          iss_valid,
  input logic          iss_lock,
  input logic          iss_last,
  input logic          breq_n,
  input logic          binit_out_n
);
  p_grant_needed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant || breq_n) |=> !iss_valid);

  p_stall_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_n |=> !iss_valid);

  p_prio_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!prio_n && !lock_q) |=> !iss_valid);

  p_lock_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_lock && !iss_last) |-> lock_q);

  p_lock_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_lock && iss_last) |-> !lock_q);

  p_binit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_q && !binit_n) |=> (!lock_q && breq_n && !iss_valid));

  p_binit_keeps_queue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_q && !binit_n && !(enq_valid && enq_ready)) |=> (fill == $past(fill)));

  p_binit_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q && fault) |=> !binit_out_n);

  p_binit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_q |=> binit_out_n);
endmodule

bind bus_issue_gate bus_issue_gate_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .obs_q       (obs_q),
  .drv_q       (drv_q),
  .binit_n     (binit_n),
  .stall_n     (stall_n),
  .prio_n      (prio_n),
  .grant       (grant),
  .fault       (fault),
  .lock_q      (lock_q),
  .fill        (fill),
  .enq_valid   (enq_valid),
  .enq_ready   (enq_ready),
  .iss_valid   (iss_valid),
  .iss_lock    (iss_lock),
  .iss_last    (iss_last),
  .breq_n      (breq_n),
  .binit_out_n (binit_out_n)
);

// File: tb/bus_issue_gate_test.sv
module bus_issue_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_observe = 1'b1, cfg_drive = 1'b1;
  logic enq_valid = 1'b0, enq_lock = 1'b0, enq_last = 1'b0;
  logic [DW-1:0] enq_data = '0;
  logic grant = 1'b0, stall_n = 1'b1, prio_n = 1'b1, binit_n = 1'b1, fault = 1'b0;
  logic enq_ready, breq_n, binit_out_n, iss_valid, iss_lock, iss_last;
  logic [DW-1:0] iss_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_issue_gate #(.DATA_W(DW), .DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_observe(cfg_observe), .cfg_drive(cfg_drive),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_data(enq_data),
    .enq_lock(enq_lock), .enq_last(enq_last), .grant(grant), .breq_n(breq_n),
    .stall_n(stall_n), .prio_n(prio_n), .binit_n(binit_n), .fault(fault),
    .binit_out_n(binit_out_n), .iss_valid(iss_valid), .iss_data(iss_data),
    .iss_lock(iss_lock), .iss_last(iss_last)
  );

  typedef struct packed {
    logic [3:0]    req;
    logic          grant;
    logic          stall_n;
    logic          prio_n;
    logic          exp_v;
    logic [DW-1:0] exp_d;
    logic          exp_breq_n;
  } vec_t;

  // queue preloaded with 11 (plain), 22 (lock), 33 (lock,last), 44 (plain)
  localparam vec_t VECS [9] = '{
    '{4'd3,  1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R3 stall blocks
    '{4'd4,  1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R4 prio blocks, no lock
    '{4'd2,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, // R2 no grant
    '{4'd1,  1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 1'b0}, // R1 order, first entry
    '{4'd5,  1'b1, 1'b1, 1'b1, 1'b1, 8'h22, 1'b0}, // R5 lock opens
    '{4'd4,  1'b1, 1'b1, 1'b0, 1'b1, 8'h33, 1'b0}, // R4 continuation passes
    '{4'd5,  1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R5 lock closed, prio blocks
    '{4'd1,  1'b1, 1'b1, 1'b1, 1'b1, 8'h44, 1'b0}, // R1 last entry
    '{4'd10, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1}  // R10 empty drops request
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d, input logic lk, input logic ls);
    enq_valid = 1'b1; enq_data = d; enq_lock = lk; enq_last = ls;
    @(posedge clk);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic obs, input logic drv);
    rst_n = 1'b0; cfg_observe = obs; cfg_drive = drv;
    grant = 1'b0; stall_n = 1'b1; prio_n = 1'b1; binit_n = 1'b1; fault = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 iss_valid", iss_valid, 0);
    chk("R11 breq_n", breq_n, 1);
    chk("R11 binit_out_n", binit_out_n, 1);
    chk("R11 enq_ready", enq_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1, 1'b1);

    // R8 drive enabled
    fault = 1'b1; step();
    chk("R8 binit_out_n low", binit_out_n, 0);
    @(negedge clk); fault = 1'b0; step();
    chk("R8 binit_out_n high", binit_out_n, 1);
    @(negedge clk);

    // preload four entries, grant low
    push(8'h11, 1'b0, 1'b0);
    push(8'h22, 1'b1, 1'b0);
    push(8'h33, 1'b1, 1'b1);
    push(8'h44, 1'b0, 1'b0);
    chk("R10 breq_n low", breq_n, 0);
    chk("R1 enq_ready full", enq_ready, 0);
    push(8'h99, 1'b0, 1'b0); // dropped: queue full (R1)

    foreach (VECS[i]) begin
      grant = VECS[i].grant; stall_n = VECS[i].stall_n; prio_n = VECS[i].prio_n;
      step();
      checks++;
      if (iss_valid !== VECS[i].exp_v || (VECS[i].exp_v && iss_data !== VECS[i].exp_d) ||
          breq_n !== VECS[i].exp_breq_n) begin
        errors++;
        $display("FAIL R%0d row %0d: actual v=%0b d=%0h breq_n=%0b expected v=%0b d=%0h breq_n=%0b",
                 VECS[i].req, i, iss_valid, iss_data, breq_n,
                 VECS[i].exp_v, VECS[i].exp_d, VECS[i].exp_breq_n);
      end
      @(negedge clk);
    end

    // R6: initialization in the middle of a locked pair under priority
    grant = 1'b0; stall_n = 1'b1; prio_n = 1'b1;
    push(8'h51, 1'b1, 1'b0);
    push(8'h52, 1'b1, 1'b1);
    grant = 1'b1; step();
    chk("R6 first half issued", {iss_valid, iss_data}, {1'b1, 8'h51});
    @(negedge clk); binit_n = 1'b0; step();
    chk("R6 no issue on init", iss_valid, 0);
    chk("R6 breq_n released", breq_n, 1);
    @(negedge clk); binit_n = 1'b1; prio_n = 1'b0; step();
    chk("R6 re-request", breq_n, 0);
    chk("R6 idle cycle", iss_valid, 0);
    @(negedge clk); step();
    chk("R6 lock cleared, prio blocks", iss_valid, 0);
    @(negedge clk); prio_n = 1'b1; step();
    chk("R6 queue kept", {iss_valid, iss_data}, {1'b1, 8'h52});
    @(negedge clk); grant = 1'b0;
    step(); @(negedge clk);

    // R7 / R9: observe and drive disabled at reset, pins raised later
    do_reset(1'b0, 1'b0);
    cfg_observe = 1'b1; cfg_drive = 1'b1;
    push(8'h61, 1'b0, 1'b0);
    push(8'h62, 1'b0, 1'b0);
    grant = 1'b1; binit_n = 1'b0; step();
    chk("R7 init ignored, issue", {iss_valid, iss_data}, {1'b1, 8'h61});
    chk("R9 breq_n held", breq_n, 0);
    @(negedge clk); fault = 1'b1; step();
    chk("R9 drive stays disabled", binit_out_n, 1);
    chk("R7 second issue", {iss_valid, iss_data}, {1'b1, 8'h62});
    @(negedge clk); fault = 1'b0; binit_n = 1'b1; grant = 1'b0;
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule